// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between serial time-division streams. Every input stream is turned into bytes, one per channel slot, and each byte is stored in a data memory indexed by input stream and channel. A connect memory holds one entry per output stream and channel. Each entry says what goes out in that slot: a byte taken from the data memory at a chosen source address, or a fixed byte that the CPU has placed in the entry itself. The same entry can also leave the slot undriven.

Frame timing comes from internal counters that start at reset. A frame has `CH` channel slots of eight bit-clocks each. Output slots run one slot behind the input slots. The byte for an output channel is fetched during the slot before it goes out and is then shifted out MSB first. The data memory is double-buffered per frame, so every output frame carries the complete input frame that came before it. A global enable input can force every output to be undriven. A small CPU port writes connect-memory entries and reads them back.

Top module: `tsi_switch`

## Requirements
- R1: In reset and afterwards until a driven entry is fetched, `tx_oe_o` and `tx_o` are all zero. After reset, every connect-memory entry reads back as 0x200, which means only the high-impedance bit is set.
- R2: Input channel c of frame f occupies cycles f*8*CH + 8*c + b after reset release, where b = 0..7 carries byte bit 7-b. Output channel c of frame f occupies cycles f*8*CH + 8*(c+1) + b. Output channel CH-1 therefore spills into the first slot of frame f+1. An entry is in connection mode when bit 8 = 0 and bit 9 = 0. The source index is taken from entry bits [SW+CW-1:0], as {stream, channel}: with the defaults, bits [4:3] give the stream and bits [2:0] give the channel. The output slot then carries the stored byte of that source, MSB first.
- R3: When bit 8 of an entry is 1 (message mode), the entry's bits [7:0] are sent in that output slot in every frame until the entry is rewritten.
- R4: When bit 9 of an entry is 1, the drive-enable for that output stream stays low for the whole channel slot. Whenever a drive-enable is low, its data bit reads 0.
- R5: While `oe_i` is low, every `tx_oe_o` bit is low in the same cycle, whatever the entries say.
- R6: Several output channels may name the same source, and each of them carries that same byte.
- R7: An entry is sampled for output channel c in the last cycle of input slot c. A write presented in an earlier cycle is used for that output. A write presented in that sampling cycle itself first takes effect one frame later.
- R8: `cpu_rdata_o` shows the entry at the `cpu_addr_i` presented in the previous cycle. A write in that same cycle is not yet visible.
- R9: Output frame f always carries input frame f-1, whether the source channel comes earlier or later than the output channel. Frame 0 carries zeros from the reset-cleared data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | N_IN | Serial input streams, MSB first |
| oe_i | input | 1 | Global output enable; low forces all outputs undriven |
| cpu_we_i | input | 1 | Connect-memory write strobe |
| cpu_addr_i | input | OSW+CW | Entry address {output stream, channel} |
| cpu_wdata_i | input | CM_W | Entry write data: [7:0] byte or source, [8] message, [9] high impedance |
| cpu_rdata_o | output | CM_W | Registered entry read data |
| tx_o | output | N_OUT | Serial output data, 0 when undriven |
| tx_oe_o | output | N_OUT | Per-stream drive enable |

## Verification
Each kind of wrong internal state shows up at the ports within about two frames:

- **Bank select flipped:** a wrong double-buffer bank select at a frame edge mixes bytes from two frames into the next output frame.
- **Slot counter off by one:** every connected channel shows its neighbour's byte, starting in the slot after the error.
- **Stale entry or drive flag:** a stale connect entry or drive flag is visible on the first bit of the following output slot.

Writes placed just before and just on a sampling cycle expose any error in entry-update ordering in the very next frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W  = 8;
  localparam int MSG_BIT = 8;
  localparam int HIZ_BIT = 9;
  localparam int CTRL_W  = 10;

  function automatic logic [BYTE_W-1:0] shift_in(logic [BYTE_W-2:0] prev, logic b);
    return {prev, b};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(logic msg, logic [BYTE_W-1:0] own,
                                                  logic [BYTE_W-1:0] fetched);
    return msg ? own : fetched;
  endfunction

  function automatic logic line_bit(logic oe, logic drive, logic msb);
    return oe & drive & msb;
  endfunction
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase #(
  parameter int CH = 8,
  localparam int CW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [2:0]    bit_idx,
  output logic [CW-1:0] slot,
  output logic          bank,
  output logic          last_bit,
  output logic          frame_end
);
  localparam logic [CW-1:0] LAST_SLOT = CW'(CH - 1);

  function automatic logic [CW-1:0] next_slot(logic [CW-1:0] s);
    return (s == LAST_SLOT) ? '0 : s + 1'b1;
  endfunction

  assign last_bit  = (bit_idx == 3'd7);
  assign frame_end = last_bit && (slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      slot    <= '0;
      bank    <= 1'b0;
    end else begin
      bit_idx <= bit_idx + 3'd1;
      if (last_bit)  slot <= next_slot(slot);
      if (frame_end) bank <= ~bank;
    end
  end
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store
  import tsi_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int CH   = 8,
  parameter int N_RD = 4,
  localparam int CW    = $clog2(CH),
  localparam int IW    = $clog2(N_IN),
  localparam int IDX_W = IW + CW,
  localparam int DEPTH = N_IN * CH
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_IN-1:0]                    rx_i,
  input  logic                               wr_now,
  input  logic [CW-1:0]                      wr_slot,
  input  logic                               wr_bank,
  input  logic [N_RD-1:0][IDX_W-1:0]         rd_idx,
  output logic [N_RD-1:0][BYTE_W-1:0]        rd_byte
);
  logic [BYTE_W-2:0] sr [N_IN];
  logic [BYTE_W-1:0] dm [2*DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_IN; s++) sr[s] <= '0;
    end else begin
      for (int s = 0; s < N_IN; s++) sr[s] <= shift_in(sr[s][BYTE_W-3:0], rx_i[s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*DEPTH; i++) dm[i] <= '0;
    end else if (wr_now) begin
      for (int s = 0; s < N_IN; s++)
        dm[{wr_bank, IW'(s), wr_slot}] <= shift_in(sr[s], rx_i[s]);
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_byte[r] = dm[{~wr_bank, rd_idx[r]}];
  end
endmodule

// File: rtl/tsi_connect_mem.sv
module tsi_connect_mem
  import tsi_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int CH    = 8,
  parameter int CM_W  = 10,
  localparam int CW = $clog2(CH),
  localparam int OW = $clog2(N_OUT),
  localparam int AW = OW + CW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_we_i,
  input  logic [AW-1:0]                cpu_addr_i,
  input  logic [CM_W-1:0]              cpu_wdata_i,
  output logic [CM_W-1:0]              cpu_rdata_o,
  input  logic [CW-1:0]                slot,
  output logic [N_OUT-1:0][CM_W-1:0]   slot_entry
);
  localparam logic [CM_W-1:0] RST_ENTRY = CM_W'(1) << HIZ_BIT;

  logic [CM_W-1:0] cm [N_OUT*CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_OUT*CH; i++) cm[i] <= RST_ENTRY;
      cpu_rdata_o <= '0;
    end else begin
      cpu_rdata_o <= cm[cpu_addr_i];
      if (cpu_we_i) cm[cpu_addr_i] <= cpu_wdata_i;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane_rd
    localparam logic [OW-1:0] OIDX = OW'(o);
    assign slot_entry[o] = cm[{OIDX, slot}];
  end
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
  import tsi_pkg::*;
#(
  parameter int SRC_W = 5,
  parameter int CM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              oe_i,
  input  logic [CM_W-1:0]   entry,
  input  logic [BYTE_W-1:0] fetch_byte,
  output logic [SRC_W-1:0]  src_idx,
  output logic              drive,
  output logic              tx,
  output logic              tx_oe
);
  logic [BYTE_W-1:0] shreg;

  if (SRC_W > BYTE_W) begin : g_ext_src
    assign src_idx = {entry[CM_W-1:CTRL_W], entry[BYTE_W-1:0]};
  end else begin : g_low_src
    assign src_idx = entry[SRC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      drive <= 1'b0;
    end else if (load) begin
      shreg <= pick_byte(entry[MSG_BIT], entry[BYTE_W-1:0], fetch_byte);
      drive <= ~entry[HIZ_BIT];
    end else begin
      shreg <= {shreg[BYTE_W-2:0], 1'b0};
    end
  end

  assign tx_oe = oe_i & drive;
  assign tx    = line_bit(oe_i, drive, shreg[BYTE_W-1]);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int CH    = 8,
  localparam int CW    = $clog2(CH),
  localparam int ISW   = $clog2(N_IN),
  localparam int OSW   = $clog2(N_OUT),
  localparam int AW    = OSW + CW,
  localparam int SRC_W = ISW + CW,
  localparam int EXT_W = (SRC_W > BYTE_W) ? SRC_W - BYTE_W : 0,
  localparam int CM_W  = CTRL_W + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  rx_i,
  input  logic             oe_i,
  input  logic             cpu_we_i,
  input  logic [AW-1:0]    cpu_addr_i,
  input  logic [CM_W-1:0]  cpu_wdata_i,
  output logic [CM_W-1:0]  cpu_rdata_o,
  output logic [N_OUT-1:0] tx_o,
  output logic [N_OUT-1:0] tx_oe_o
);
  logic [2:0]                      bit_idx;
  logic [CW-1:0]                   slot;
  logic                            bank;
  logic                            last_bit;
  logic                            frame_end;
  logic [N_OUT-1:0][CM_W-1:0]      slot_entry;
  logic [N_OUT-1:0][SRC_W-1:0]     src_idx;
  logic [N_OUT-1:0][BYTE_W-1:0]    fetch_byte;
  logic [N_OUT-1:0]                lane_drive;

  tsi_timebase #(.CH(CH)) u_time (
    .clk, .rst_n, .bit_idx, .slot, .bank, .last_bit, .frame_end
  );

  tsi_rx_store #(.N_IN(N_IN), .CH(CH), .N_RD(N_OUT)) u_store (
    .clk, .rst_n, .rx_i,
    .wr_now (last_bit),
    .wr_slot(slot),
    .wr_bank(bank),
    .rd_idx (src_idx),
    .rd_byte(fetch_byte)
  );

  tsi_connect_mem #(.N_OUT(N_OUT), .CH(CH), .CM_W(CM_W)) u_cmem (
    .clk, .rst_n, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_rdata_o,
    .slot, .slot_entry
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    tsi_tx_lane #(.SRC_W(SRC_W), .CM_W(CM_W)) u_lane (
      .clk, .rst_n,
      .load      (last_bit),
      .oe_i,
      .entry     (slot_entry[o]),
      .fetch_byte(fetch_byte[o]),
      .src_idx   (src_idx[o]),
      .drive     (lane_drive[o]),
      .tx        (tx_o[o]),
      .tx_oe     (tx_oe_o[o])
    );
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int N_OUT = 4,
  parameter int AW    = 5,
  parameter int CM_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_i,
  input logic             cpu_we_i,
  input logic [AW-1:0]    cpu_addr_i,
  input logic [CM_W-1:0]  cpu_wdata_i,
  input logic [CM_W-1:0]  cpu_rdata_o,
  input logic [N_OUT-1:0] tx_o,
  input logic [N_OUT-1:0] tx_oe_o,
  input logic             last_bit,
  input logic             frame_end,
  input logic             bank,
  input logic [N_OUT-1:0] lane_drive
);
  AST_RESET_UNDRIVEN: assert property (@(posedge clk)
    !rst_n |-> (tx_oe_o == '0)); // R1

  AST_GLOBAL_OE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> (tx_oe_o == '0)); // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_o & ~tx_oe_o) == '0)); // R4

  AST_DRIVE_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !last_bit |=> $stable(lane_drive)); // R4

  AST_BANK_FLIPS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bank != $past(bank))); // R9

  AST_BANK_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(bank)); // R9

  AST_READBACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we_i ##1 (cpu_addr_i == $past(cpu_addr_i)) |=>
      (cpu_rdata_o == $past(cpu_wdata_i, 2))); // R8
endmodule

bind tsi_switch tsi_switch_chk #(.N_OUT(N_OUT), .AW(AW), .CM_W(CM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .oe_i       (oe_i),
  .cpu_we_i   (cpu_we_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_wdata_i(cpu_wdata_i),
  .cpu_rdata_o(cpu_rdata_o),
  .tx_o       (tx_o),
  .tx_oe_o    (tx_oe_o),
  .last_bit   (last_bit),
  .frame_end  (frame_end),
  .bank       (bank),
  .lane_drive (lane_drive)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int NI = 4, NO = 4, CH = 8;
  localparam int FB = CH * 8;
  localparam int NF = 11;
  localparam int TOTAL = NF * FB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] rx = '0;
  logic          oe = 1'b1;
  logic          we = 1'b0;
  logic [4:0]    addr = '0;
  logic [9:0]    wdata = '0;
  logic [9:0]    rdata;
  logic [NO-1:0] tx, txoe;

  always #4 clk = ~clk;

  tsi_switch #(.N_IN(NI), .N_OUT(NO), .CH(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .oe_i(oe), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .tx_o(tx), .tx_oe_o(txoe)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] hist   [0:15][0:NI-1][0:CH-1];
  logic [9:0] shadow [0:NO-1][0:CH-1];
  string      etag   [0:NO-1][0:CH-1];
  logic [9:0] cfg    [0:NO*CH-1];
  string      ctag   [0:NO*CH-1];
  logic [7:0] f_byte [0:NO-1];
  logic       f_en   [0:NO-1];
  string      f_tag  [0:NO-1];
  logic       rd_pend = 0;
  logic [9:0] rd_exp;
  string      rd_tag;

  function automatic logic [7:0] src_byte(logic [9:0] e, int fr);
    if (e[8]) return e[7:0];
    if (fr <= 0) return 8'h00;
    return hist[fr-1][e[4:3]][e[2:0]];
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic interval(int t);
    int fr, slot, b;
    logic rd_now;
    string rtag, tg;
    logic eo, et;
    logic [9:0] e;
    fr = t / FB; slot = (t % FB) / 8; b = t % 8;
    if (t % FB == 0)
      for (int s = 0; s < NI; s++)
        for (int c = 0; c < CH; c++) hist[fr][s][c] = 8'($urandom);
    for (int s = 0; s < NI; s++) rx[s] = hist[fr][s][slot][7-b];
    we = 0; addr = '0; wdata = '0; oe = 1; rd_now = 0; rtag = "";
    if (fr == 4 || fr == 5) oe = 1'($urandom % 2);
    if (t == 0) begin addr = 5'd5; rd_now = 1; rtag = "R1"; end
    if (t >= 1 && t <= NO*CH) begin we = 1; addr = 5'(t-1); wdata = cfg[t-1]; end
    if (t >= 40 && t < 48) begin addr = 5'((t-40)*3+1); rd_now = 1; rtag = "R8"; end
    // R7: one write just before the sampling cycle, one on it
    if (fr == 7 && slot == 4 && b == 6) begin we = 1; addr = {2'd2, 3'd4}; wdata = {2'b01, 8'h3C}; end
    if (fr == 7 && slot == 4 && b == 7) begin we = 1; addr = {2'd3, 3'd4}; wdata = {2'b01, 8'hC3}; end
    #1;
    for (int o = 0; o < NO; o++) begin
      eo = oe & f_en[o];
      et = eo ? f_byte[o][7-b] : 1'b0;
      tg = (!oe && f_en[o]) ? "R5" : f_tag[o];
      check(tg, $sformatf("tx_oe_o[%0d] t=%0d", o, t), 32'(txoe[o]), 32'(eo));
      check(tg, $sformatf("tx_o[%0d] t=%0d", o, t), 32'(tx[o]), 32'(et));
    end
    if (rd_pend) check(rd_tag, $sformatf("cpu_rdata_o t=%0d", t), 32'(rdata), 32'(rd_exp));
    rd_pend = rd_now;
    if (rd_now) begin rd_exp = shadow[addr[4:3]][addr[2:0]]; rd_tag = rtag; end
    if (b == 7)
      for (int o = 0; o < NO; o++) begin
        e = shadow[o][slot];
        f_byte[o] = src_byte(e, fr);
        f_en[o] = !e[9];
        f_tag[o] = e[9] ? "R4" : etag[o][slot];
      end
    if (we) begin
      shadow[addr[4:3]][addr[2:0]] = wdata;
      if (fr == 7) etag[addr[4:3]][addr[2:0]] = "R7";
      else etag[addr[4:3]][addr[2:0]] = ctag[addr];
    end
  endtask

  initial begin
    logic [7:0] r, v;
    void'($urandom(32'd1234));
    for (int o = 0; o < NO; o++) begin
      f_byte[o] = '0; f_en[o] = 0; f_tag[o] = "R1";
      for (int c = 0; c < CH; c++) begin shadow[o][c] = 10'h200; etag[o][c] = "R1"; end
    end
    for (int i = 0; i < NO*CH; i++) begin
      r = 8'($urandom % 8); v = 8'($urandom);
      if (r == 0) begin cfg[i] = {2'b10, v}; ctag[i] = "R4"; end
      else if (r < 3) begin cfg[i] = {2'b01, v}; ctag[i] = "R3"; end
      else begin
        cfg[i] = {2'b00, 3'b000, v[4:0]};
        ctag[i] = (int'(v[2:0]) >= i % CH) ? "R9" : "R2";
      end
    end
    cfg[1]  = {2'b00, 8'h00}; ctag[1]  = "R9";  // frame 0 reads cleared memory
    cfg[2]  = {2'b00, 8'h1E}; ctag[2]  = "R6";  // stream 3 channel 6
    cfg[13] = {2'b00, 8'h1E}; ctag[13] = "R6";
    cfg[23] = {2'b01, 8'hA5}; ctag[23] = "R3";
    cfg[24] = {2'b10, 8'h5A}; ctag[24] = "R4";
    cfg[9]  = {2'b00, 8'h07}; ctag[9]  = "R2";  // stream 0 channel 7
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    interval(0);
    for (int t = 1; t < TOTAL; t++) begin
      @(posedge clk); #1;
      interval(t);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule